// File: doc/BRIEF.md
# Packed Sub-Word Pipelined Multiplier

This block is a multiplier function unit for a datapath in which an operation starts when its operands are written in. Each issued operation carries two 32-bit operands and a mode bit. In full-word mode it returns the low 32 bits of the 64-bit product. In packed mode each operand carries two independent 16-bit values, and the unit computes both 16x16 products in the same pass. Each lane keeps the low 16 bits of its own product.

The datapath is cut into three clocked stages. The first stage builds the partial-product rows. In packed mode it masks every term that would cross between the lanes. The second stage reduces the rows to a sum row and a carry row with a tree of 3:2 carry-save compressors. In packed mode that tree drops any carry that would enter bit 16. The third stage adds the two rows with a carry-propagate adder that is split at the lane boundary.

A valid flag and the mode bit travel down the pipeline with the data, so modes can change on every operation. Each stage advances when the next stage is empty or is being drained. The result port is a sink that always drains, so one operation per cycle is accepted.

Top module: `mulpk_unit`

## Requirements
- R1: With `packed_mode`=0, `result` equals the low 32 bits of the unsigned product `op_a`*`op_b`.
- R2: With `packed_mode`=1, `result[15:0]` is the low 16 bits of `op_a[15:0]`*`op_b[15:0]`, and `result[31:16]` is the low 16 bits of `op_a[31:16]`*`op_b[31:16]`.
- R3: In packed mode no product term or carry crosses bit 16. A lower lane whose product overflows 16 bits leaves the upper half of the result unchanged, and upper-lane operands have no effect on the lower half.
- R4: An operation sampled with `in_valid`=1 at a rising edge makes `out_valid` high right after the third rising edge, counting the sampling edge as the first.
- R5: Operations issued on consecutive cycles are all accepted, and their results appear on consecutive cycles in issue order.
- R6: After reset `out_valid` is 0, and `out_valid` is high only for cycles that correspond to an issued operation. The number of results equals the number of issued operations.
- R7: While `out_valid` is 0, `result` is all zeros.
- R8: The mode is taken per operation. Alternating the mode on back-to-back operations gives each result its own mode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Issue strobe; operands and mode are sampled when high |
| op_a | input | 32 | First operand (two 16-bit lanes in packed mode) |
| op_b | input | 32 | Second operand (two 16-bit lanes in packed mode) |
| packed_mode | input | 1 | 0 = full-word multiply, 1 = two packed 16-bit multiplies |
| out_valid | output | 1 | High for one cycle per completed operation |
| result | output | 32 | Product, zero when out_valid is low |

## Verification
The bench aims at the lane boundary. It uses all-ones lanes whose products overflow 16 bits. A design that let a lower-lane carry or a cross-lane partial product through would show a 1 leaking into bit 16 or a corrupted upper half. Back-to-back operations that alternate the mode would catch a mode bit that lagged its data by a stage. The same sequence would catch a stage that stalled or duplicated an entry, because results would arrive out of order or late. Every result is also checked for the exact cycle it appears in, so an added or missing pipeline register shows up as a latency failure.

// File: rtl/mulpk_pkg.sv
package mulpk_pkg;

  // Row count after one level of 3:2 compression
  function automatic int csa_next(input int n);
    return (n / 3) * 2 + (n % 3);
  endfunction

  // Row count entering level lvl of the reduction tree
  function automatic int csa_rows_at(input int n0, input int lvl);
    int n;
    n = n0;
    for (int i = 0; i < 64; i++) begin
      if (i < lvl && n > 2) n = csa_next(n);
    end
    return n;
  endfunction

  // Number of levels needed to reach two rows
  function automatic int csa_depth(input int n0);
    int n;
    int d;
    n = n0;
    d = 0;
    for (int i = 0; i < 64; i++) begin
      if (n > 2) begin
        n = csa_next(n);
        d++;
      end
    end
    return d;
  endfunction

endpackage

// File: rtl/mulpk_ppgen.sv
module mulpk_ppgen #(
  parameter int W = 32
) (
  input  logic [W-1:0] a,
  input  logic [W-1:0] b,
  input  logic         packed_sel,
  output logic [W-1:0] rows [W]
);
  localparam int H = W / 2;

  for (genvar i = 0; i < W; i++) begin : g_row
    logic [W-1:0] full_row;
    logic [W-1:0] lane_row;
    assign full_row = b[i] ? (a << i) : '0;
    if (i < H) begin : g_lo
      // lower lane: only a[H-1:0] contributes, bits at H and above are cut
      logic [W-1:0] shifted;
      assign shifted  = {{H{1'b0}}, a[H-1:0]} << i;
      assign lane_row = b[i] ? {{H{1'b0}}, shifted[H-1:0]} : '0;
    end else begin : g_hi
      // upper lane: a[W-1:H] weighted by b bit (i-H), kept inside the upper half
      logic [W-1:0] shifted;
      assign shifted  = {{H{1'b0}}, a[W-1:H]} << (i - H);
      assign lane_row = b[i] ? {shifted[H-1:0], {H{1'b0}}} : '0;
    end
    assign rows[i] = packed_sel ? lane_row : full_row;
  end

endmodule

// File: rtl/mulpk_csa_tree.sv
module mulpk_csa_tree
  import mulpk_pkg::*;
#(
  parameter int W = 32,
  parameter int N = 32
) (
  input  logic [W-1:0] rows_in [N],
  input  logic         packed_sel,
  output logic [W-1:0] sum_row,
  output logic [W-1:0] carry_row
);
  localparam int H    = W / 2;
  localparam int NLEV = csa_depth(N);

  logic [W-1:0] lv [NLEV+1][N];
  logic [W-1:0] carry_mask;

  // In packed mode a carry may not enter the lowest bit of the upper lane
  assign carry_mask = packed_sel ? ~(W'(1) << H) : '1;

  for (genvar j = 0; j < N; j++) begin : g_in
    assign lv[0][j] = rows_in[j];
  end

  for (genvar l = 0; l < NLEV; l++) begin : g_lvl
    localparam int NIN  = csa_rows_at(N, l);
    localparam int NGRP = NIN / 3;
    localparam int NOUT = csa_rows_at(N, l + 1);
    for (genvar j = 0; j < N; j++) begin : g_out
      if (j < 2 * NGRP) begin : g_csa
        localparam int G = j / 2;
        if (j % 2 == 0) begin : g_sum
          assign lv[l+1][j] = lv[l][3*G] ^ lv[l][3*G+1] ^ lv[l][3*G+2];
        end else begin : g_car
          assign lv[l+1][j] = ((lv[l][3*G] & lv[l][3*G+1]) |
                               (lv[l][3*G] & lv[l][3*G+2]) |
                               (lv[l][3*G+1] & lv[l][3*G+2])) << 1 & carry_mask;
        end
      end else if (j < NOUT) begin : g_pass
        assign lv[l+1][j] = lv[l][j + NGRP];
      end else begin : g_zero
        assign lv[l+1][j] = '0;
      end
    end
  end

  assign sum_row   = lv[NLEV][0];
  assign carry_row = lv[NLEV][1];

endmodule

// File: rtl/mulpk_final_add.sv
module mulpk_final_add #(
  parameter int W = 32
) (
  input  logic [W-1:0] x,
  input  logic [W-1:0] y,
  input  logic         packed_sel,
  output logic [W-1:0] sum,
  output logic         lane_carry
);
  localparam int H = W / 2;

  logic [H:0]   lo_sum;
  logic [H-1:0] hi_sum;
  logic         hi_cin;

  assign lo_sum     = {1'b0, x[H-1:0]} + {1'b0, y[H-1:0]};
  assign lane_carry = lo_sum[H];
  assign hi_cin     = packed_sel ? 1'b0 : lane_carry;
  assign hi_sum     = x[W-1:H] + y[W-1:H] + {{(H-1){1'b0}}, hi_cin};
  assign sum        = {hi_sum, lo_sum[H-1:0]};

endmodule

// File: rtl/mulpk_unit.sv
module mulpk_unit #(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         in_valid,
  input  logic [W-1:0] op_a,
  input  logic [W-1:0] op_b,
  input  logic         packed_mode,
  output logic         out_valid,
  output logic [W-1:0] result
);
  localparam int   H          = W / 2;
  localparam logic SINK_READY = 1'b1;

  // arithmetic model used by the assertions
  function automatic logic [W-1:0] model_product(input logic [W-1:0] a,
                                                 input logic [W-1:0] b,
                                                 input logic       pk);
    logic [W-1:0] full;
    logic [H-1:0] lo;
    logic [H-1:0] hi;
    full = a * b;
    lo   = a[H-1:0] * b[H-1:0];
    hi   = a[W-1:H] * b[W-1:H];
    return pk ? {hi, lo} : full;
  endfunction

  // ---------------- stage 1: partial products ----------------
  logic [W-1:0] pp_rows [W];
  logic [W-1:0] s1_rows [W];
  logic         s1_v, s1_mode;
  logic         s1_rdy, s2_rdy, s3_rdy;
  logic         s1_load, s2_load, s3_load;
  logic         s3_v;

  mulpk_ppgen #(.W(W)) i_ppgen (
    .a          (op_a),
    .b          (op_b),
    .packed_sel (packed_mode),
    .rows       (pp_rows)
  );

  assign s3_rdy  = !s3_v || SINK_READY;
  assign s1_load = in_valid && s1_rdy;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s1_v <= 1'b0;
    end else if (s1_rdy) begin
      s1_v <= in_valid;
    end
  end

  always_ff @(posedge clk) begin
    if (s1_load) begin
      s1_mode <= packed_mode;
      for (int i = 0; i < W; i++) s1_rows[i] <= pp_rows[i];
    end
  end

  // ---------------- stage 2: carry-save reduction ----------------
  logic [W-1:0] tree_sum, tree_car;
  logic [W-1:0] s2_sum, s2_car;
  logic         s2_v, s2_mode;

  mulpk_csa_tree #(.W(W), .N(W)) i_tree (
    .rows_in    (s1_rows),
    .packed_sel (s1_mode),
    .sum_row    (tree_sum),
    .carry_row  (tree_car)
  );

  assign s2_rdy  = !s2_v || s3_rdy;
  assign s1_rdy  = !s1_v || s2_rdy;
  assign s2_load = s1_v && s2_rdy;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s2_v <= 1'b0;
    end else if (s2_rdy) begin
      s2_v <= s1_v;
    end
  end

  always_ff @(posedge clk) begin
    if (s2_load) begin
      s2_mode <= s1_mode;
      s2_sum  <= tree_sum;
      s2_car  <= tree_car;
    end
  end

  // ---------------- stage 3: carry-propagate add ----------------
  logic [W-1:0] add_out;
  logic         lane_carry;
  logic [W-1:0] s3_res;

  mulpk_final_add #(.W(W)) i_add (
    .x          (s2_sum),
    .y          (s2_car),
    .packed_sel (s2_mode),
    .sum        (add_out),
    .lane_carry (lane_carry)
  );

  assign s3_load = s2_v && s3_rdy;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s3_v <= 1'b0;
    end else if (s3_rdy) begin
      s3_v <= s2_v;
    end
  end

  always_ff @(posedge clk) begin
    if (s3_load) s3_res <= add_out;
  end

  assign out_valid = s3_v;
  assign result    = s3_v ? s3_res : '0;

  // ---------------- assertions ----------------
  assert_latency_R4: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |-> ##3 out_valid)
    else $error("issued operation did not complete after three edges");

  assert_origin_R6: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> $past(in_valid, 3))
    else $error("result without a matching issue");

  assert_idle_zero_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !out_valid |-> (result == '0))
    else $error("result not zero while idle");

  assert_full_word_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !$past(packed_mode, 3)) |->
      (result == model_product($past(op_a, 3), $past(op_b, 3), 1'b0)))
    else $error("full-word product mismatch");

  assert_packed_lanes_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && $past(packed_mode, 3)) |->
      (result == model_product($past(op_a, 3), $past(op_b, 3), 1'b1)))
    else $error("packed product mismatch");

  // R3: a lower-lane carry never reaches the upper half in packed mode
  assert_lane_isolated_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && $past(packed_mode, 3) && ($past(op_a, 3) >> H) == '0) |->
      (result[W-1:H] == '0))
    else $error("carry crossed lane boundary");

endmodule

// File: tb/test_mulpk_unit.sv
`timescale 1ns/100ps
module test_mulpk_unit;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        in_valid = 1'b0;
  logic [31:0] op_a = '0;
  logic [31:0] op_b = '0;
  logic        packed_mode = 1'b0;
  logic        out_valid;
  logic [31:0] result;

  int checks = 0;
  int failures = 0;
  int cyc = 0;
  int issued = 0;
  int retired = 0;
  bit done = 0;

  logic [31:0] exp_q [$];
  int          cyc_q [$];
  string       tag_q [$];

  mulpk_unit i_mulpk_unit (
    .clk, .rst_n, .in_valid, .op_a, .op_b, .packed_mode, .out_valid, .result
  );

  always #2.5 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  // bench model: shift-and-add, lane by lane
  function automatic logic [31:0] expect_of(input logic [31:0] a, input logic [31:0] b,
                                            input logic pk);
    logic [63:0] acc;
    logic [31:0] la, lb;
    logic [15:0] lanes [2];
    if (!pk) begin
      acc = '0;
      for (int i = 0; i < 32; i++) if (b[i]) acc = acc + ({32'd0, a} << i);
      return acc[31:0];
    end
    for (int k = 0; k < 2; k++) begin
      la = {16'd0, a[16*k +: 16]};
      lb = {16'd0, b[16*k +: 16]};
      acc = '0;
      for (int i = 0; i < 16; i++) if (lb[i]) acc = acc + ({32'd0, la} << i);
      lanes[k] = acc[15:0];
    end
    return {lanes[1], lanes[0]};
  endfunction

  task automatic check(input bit ok, input string tag, input logic [31:0] act,
                       input logic [31:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // driver: one operation in the current cycle
  task automatic issue(input logic [31:0] a, input logic [31:0] b, input logic pk,
                       input string tag);
    @(negedge clk);
    in_valid = 1'b1; op_a = a; op_b = b; packed_mode = pk;
    exp_q.push_back(expect_of(a, b, pk));
    cyc_q.push_back(cyc + 3);
    tag_q.push_back(tag);
    issued++;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      in_valid = 1'b0; op_a = 32'hdead_beef; op_b = 32'h5a5a_a5a5; packed_mode = 1'b1;
    end
  endtask

  // monitor
  always @(negedge clk) begin
    if (rst_n && !done) begin
      if (out_valid) begin
        retired++;
        if (exp_q.size() == 0) begin
          check(1'b0, "R6 unexpected result", result, 32'h0);
        end else begin
          logic [31:0] e;
          int          c;
          string       t;
          e = exp_q.pop_front();
          c = cyc_q.pop_front();
          t = tag_q.pop_front();
          check(result == e, t, result, e);
          check(cyc == c, {t, " R4 latency"}, cyc, c);
        end
      end else begin
        check(result == 32'h0, "R7 idle result", result, 32'h0);
      end
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    check(out_valid == 1'b0, "R6 reset out_valid", {31'd0, out_valid}, 32'h0);
    check(result == 32'h0, "R7 reset result", result, 32'h0);
    rst_n = 1'b1;
    idle(2);

    // R1 full-word
    issue(32'h0000_0000, 32'h1234_5678, 1'b0, "R1 zero");
    issue(32'h0000_0001, 32'hcafe_f00d, 1'b0, "R1 one");
    issue(32'hffff_ffff, 32'hffff_ffff, 1'b0, "R1 all ones");
    issue(32'h1234_5678, 32'h9abc_def0, 1'b0, "R1 mixed");
    issue(32'h0001_0000, 32'h0001_0000, 1'b0, "R1 overflow to zero");
    issue(32'h0000_ffff, 32'h0000_ffff, 1'b0, "R1 cross carry");
    idle(4);
    // R2 packed
    issue(32'h0003_0005, 32'h0007_000b, 1'b1, "R2 small lanes");
    issue(32'hffff_ffff, 32'hffff_ffff, 1'b1, "R2 all ones");
    issue(32'h1234_abcd, 32'h5678_ef01, 1'b1, "R2 mixed");
    idle(3);
    // R3 lane isolation
    issue(32'h0000_ffff, 32'h0000_ffff, 1'b1, "R3 low lane overflow");
    issue(32'hffff_0000, 32'h0000_ffff, 1'b1, "R3 upper a only");
    issue(32'h0000_ffff, 32'hffff_0000, 1'b1, "R3 cross operands");
    issue(32'h8000_8000, 32'h0002_0002, 1'b1, "R3 lane top bit");
    idle(4);
    // R8 alternating modes back to back, R5 throughput
    for (int i = 0; i < 8; i++)
      issue(32'h0000_ffff + 32'(i) * 32'h0101_0101, 32'hffff_0003 - 32'(i) * 32'h0033_0011,
            i[0], (i[0] ? "R8 alt packed" : "R8 alt full"));
    idle(2);
    // R5 stream of pseudo-random operations, gaps mixed in
    begin
      logic [31:0] s;
      s = 32'h1ace_b00c;
      for (int i = 0; i < 60; i++) begin
        s = {s[30:0], s[31] ^ s[21] ^ s[1] ^ s[0]};
        if (s[3:2] == 2'b00) idle(1);
        issue(s, {s[15:0], s[31:16]} ^ 32'h3c3c_5a5a, s[7], "R5 stream");
      end
    end
    idle(6);
    check(exp_q.size() == 0, "R6 pending results", 32'(exp_q.size()), 32'h0);
    check(retired == issued, "R6 result count", 32'(retired), 32'(issued));
    done = 1;
    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      done = 1;
      failures++;
      checks++;
      $display("FAIL watchdog actual=%h expected=%h", 32'h1, 32'h0);
      $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

endmodule